// File: doc/BRIEF.md
# Scan-out Fetch Address Sequencer

This block drives the address side of a display scan-out fetch engine. It walks a word-addressed window of memory, from a base byte address up to an inclusive ceiling byte address, and issues one burst read at a time on a simple request/grant/done memory port. It keeps a running count of the words that have landed in the downstream pixel FIFO and takes that count down as the pixel side pops words. A programmable fill threshold decides when the next burst may go out.

Two modes exist. In palette mode, the block fetches a fixed 32-byte (8-word) palette that starts at the base address, ignores the programmed ceiling, raises a single palette-loaded pulse and then stays quiet. In frame mode, it streams the window again and again. When the last burst of a pass completes, it raises an end-of-frame pulse and wraps back to the base. A base/ceiling pair written by software goes into a pending copy. That copy becomes active only at a frame boundary, so a page flip never mixes an old base with a new ceiling.

Top module: `fetch_addr_seq`

## Requirements
- R1: After reset, mem_req, frame_end, pal_done and underflow are low and fifo_level is 0.
- R2: burst_sel selects the burst size in 4-byte words: 0→1, 1→2, 2→4, 3→8, 4→16. Values 5 to 7 act as 16. mem_len never exceeds the selected size.
- R3: In frame mode (mode_pal=0), requests start at the base and advance by mem_len words (4 bytes each) per burst. The last burst is shortened so that it ends exactly on the word that holds the ceiling byte.
- R4: When the done of a pass's last burst arrives, frame_end pulses for one cycle and the next request starts again at the base.
- R5: A pair written with win_wr is used only from the next pass, which starts at frame_end or at a start from idle. The remaining bursts of the current pass still use the old ceiling.
- R6: In palette mode (mode_pal=1), exactly 8 words are fetched starting at the base, whatever the ceiling. pal_done pulses once after the last done. No further request is made until run_en is cleared and set again.
- R7: A new burst is requested only when fifo_level ≤ fifo_thresh and fifo_level ≤ depth − 16.
- R8: fifo_level rises by the burst length at each mem_done and falls by one for each pix_pop while it is nonzero.
- R9: A pix_pop while fifo_level is 0 pulses underflow in the following cycle and leaves fifo_level at 0.
- R10: Once raised, mem_req holds with mem_addr and mem_len stable until mem_gnt. Only one burst is outstanding at a time.
- R11: With run_en low, no new burst is started. A burst that has already been requested is still completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Run the fetch engine |
| mode_pal | input | 1 | 1 = palette pass, 0 = frame streaming; sampled at start |
| burst_sel | input | 3 | Burst size code |
| fifo_thresh | input | FILL_W | Fill level at or below which a burst may issue |
| win_wr | input | 1 | Write strobe for the pending base/ceiling pair |
| win_base | input | ADDR_W | Base byte address |
| win_ceil | input | ADDR_W | Inclusive ceiling byte address |
| mem_req | output | 1 | Burst request |
| mem_addr | output | ADDR_W | Burst start byte address |
| mem_len | output | LEN_W | Burst length in words |
| mem_gnt | input | 1 | Request accepted |
| mem_done | input | 1 | All words of the burst delivered |
| pix_pop | input | 1 | Pixel side takes one word |
| fifo_level | output | FILL_W | Words held in the pixel FIFO |
| frame_end | output | 1 | One-cycle pulse at the end of a frame pass |
| pal_done | output | 1 | One-cycle pulse when the palette is loaded |
| underflow | output | 1 | One-cycle pulse on a pop from an empty FIFO |

## Verification
The bench builds a window that is not a whole number of bursts. If the shortening of the final burst is wrong, the last burst overshoots the ceiling or the pass never ends. A new pair is written after the first grant of a pass. If the shadow logic leaks, the remaining bursts move to the new base early, or the old base is combined with the new ceiling. The palette pass gets a huge ceiling and a 2-word burst, so a design that used the programmed ceiling would keep fetching, and one that re-armed would issue requests after pal_done. A zero threshold shows whether requests stall until the FIFO is drained, and a pop from an empty FIFO shows whether the level wraps instead of flagging underflow.

// File: rtl/fas_pkg.sv
package fas_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_REQ,
        ST_WAIT,
        ST_PARK
    } seq_state_e;

    localparam int WORD_BYTES_LOG = 2;
    localparam int PAL_WORDS      = 8;

endpackage

// File: rtl/fas_window.sv
module fas_window #(
    parameter int WORD_W    = 30,
    parameter int PAL_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] base_w,
    input  logic [WORD_W-1:0] ceil_w,
    input  logic              load,
    input  logic              load_pal,
    output logic [WORD_W-1:0] pend_base_w,
    output logic [WORD_W-1:0] act_ceil_w
);

    typedef struct packed {
        logic [WORD_W-1:0] pend_base;
        logic [WORD_W-1:0] pend_ceil;
        logic [WORD_W-1:0] act_ceil;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (load) begin
            win_d.act_ceil = load_pal ? (win_q.pend_base + WORD_W'(PAL_WORDS - 1))
                                      : win_q.pend_ceil;
        end
        if (wr) begin
            win_d.pend_base = base_w;
            win_d.pend_ceil = ceil_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign pend_base_w = win_q.pend_base;
    assign act_ceil_w  = win_q.act_ceil;

endmodule

// File: rtl/fas_burst.sv
module fas_burst #(
    parameter int WORD_W        = 30,
    parameter int MAX_BURST_LOG = 4,
    parameter int LEN_W         = MAX_BURST_LOG + 1
) (
    input  logic [WORD_W-1:0] cur_w,
    input  logic [WORD_W-1:0] ceil_w,
    input  logic [2:0]        sel,
    output logic [LEN_W-1:0]  len,
    output logic              last
);

    logic [WORD_W-1:0] remain;
    logic [2:0]        sel_c;
    logic [LEN_W-1:0]  bw;

    always_comb begin
        remain = ceil_w - cur_w + WORD_W'(1);
        sel_c  = (int'(sel) > MAX_BURST_LOG) ? 3'(MAX_BURST_LOG) : sel;
        bw     = LEN_W'(1) << sel_c;
        if (remain >= WORD_W'(bw)) begin
            len  = bw;
            last = (remain == WORD_W'(bw));
        end else begin
            len  = LEN_W'(remain);
            last = 1'b1;
        end
    end

endmodule

// File: rtl/fas_fill.sv
module fas_fill #(
    parameter int FILL_W = 7,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [LEN_W-1:0]  add_len,
    input  logic              pop,
    output logic [FILL_W-1:0] level,
    output logic              underflow
);

    typedef struct packed {
        logic [FILL_W-1:0] level;
        logic              uflow;
    } fill_t;

    fill_t f_d, f_q;

    always_comb begin
        f_d       = f_q;
        f_d.uflow = pop && (f_q.level == '0);
        if (done)
            f_d.level = f_d.level + FILL_W'(add_len);
        if (pop && (f_q.level != '0))
            f_d.level = f_d.level - FILL_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign level     = f_q.level;
    assign underflow = f_q.uflow;

endmodule

// File: rtl/fetch_addr_seq.sv
module fetch_addr_seq #(
    parameter int ADDR_W        = 32,
    parameter int FIFO_DEPTH    = 64,
    parameter int MAX_BURST_LOG = 4,
    parameter int LEN_W         = MAX_BURST_LOG + 1,
    parameter int FILL_W        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              mode_pal,
    input  logic [2:0]        burst_sel,
    input  logic [FILL_W-1:0] fifo_thresh,
    input  logic              win_wr,
    input  logic [ADDR_W-1:0] win_base,
    input  logic [ADDR_W-1:0] win_ceil,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LEN_W-1:0]  mem_len,
    input  logic              mem_gnt,
    input  logic              mem_done,
    input  logic              pix_pop,
    output logic [FILL_W-1:0] fifo_level,
    output logic              frame_end,
    output logic              pal_done,
    output logic              underflow
);
    import fas_pkg::*;

    localparam int WORD_W   = ADDR_W - WORD_BYTES_LOG;
    localparam int FILL_CAP = FIFO_DEPTH - (1 << MAX_BURST_LOG);

    typedef struct packed {
        seq_state_e        state;
        logic [WORD_W-1:0] cur;
        logic [LEN_W-1:0]  len;
        logic              last;
        logic              pal;
        logic              fend;
        logic              pdone;
    } seq_t;

    seq_t s_d, s_q;

    logic              load, load_pal;
    logic [WORD_W-1:0] pend_base_w, act_ceil_w;
    logic [LEN_W-1:0]  blen;
    logic              blast;
    logic              fill_done;

    fas_window #(.WORD_W(WORD_W), .PAL_WORDS(PAL_WORDS)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (win_wr),
        .base_w     (win_base[ADDR_W-1:WORD_BYTES_LOG]),
        .ceil_w     (win_ceil[ADDR_W-1:WORD_BYTES_LOG]),
        .load       (load),
        .load_pal   (load_pal),
        .pend_base_w(pend_base_w),
        .act_ceil_w (act_ceil_w)
    );

    fas_burst #(.WORD_W(WORD_W), .MAX_BURST_LOG(MAX_BURST_LOG), .LEN_W(LEN_W)) u_burst (
        .cur_w (s_q.cur),
        .ceil_w(act_ceil_w),
        .sel   (burst_sel),
        .len   (blen),
        .last  (blast)
    );

    assign fill_done = mem_done && (s_q.state == ST_WAIT);

    fas_fill #(.FILL_W(FILL_W), .LEN_W(LEN_W)) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (fill_done),
        .add_len  (s_q.len),
        .pop      (pix_pop),
        .level    (fifo_level),
        .underflow(underflow)
    );

    always_comb begin
        s_d       = s_q;
        s_d.fend  = 1'b0;
        s_d.pdone = 1'b0;
        load      = 1'b0;
        load_pal  = s_q.pal;
        unique case (s_q.state)
            ST_IDLE: begin
                if (run_en) begin
                    load      = 1'b1;
                    load_pal  = mode_pal;
                    s_d.pal   = mode_pal;
                    s_d.cur   = pend_base_w;
                    s_d.state = ST_ARM;
                end
            end
            ST_ARM: begin
                if (!run_en)
                    s_d.state = ST_IDLE;
                else if ((fifo_level <= fifo_thresh) && (fifo_level <= FILL_W'(FILL_CAP)))
                    s_d.state = ST_REQ;
            end
            ST_REQ: begin
                if (mem_gnt) begin
                    s_d.len   = blen;
                    s_d.last  = blast;
                    s_d.cur   = s_q.cur + WORD_W'(blen);
                    s_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_done) begin
                    if (!s_q.last) begin
                        s_d.state = ST_ARM;
                    end else if (s_q.pal) begin
                        s_d.pdone = 1'b1;
                        s_d.state = ST_PARK;
                    end else begin
                        s_d.fend  = 1'b1;
                        load      = 1'b1;
                        s_d.cur   = pend_base_w;
                        s_d.state = ST_ARM;
                    end
                end
            end
            ST_PARK: begin
                if (!run_en)
                    s_d.state = ST_IDLE;
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_req   = (s_q.state == ST_REQ);
    assign mem_addr  = {s_q.cur, {WORD_BYTES_LOG{1'b0}}};
    assign mem_len   = blen;
    assign frame_end = s_q.fend;
    assign pal_done  = s_q.pdone;

endmodule

// File: rtl/fas_checks.sv
module fas_checks #(
    parameter int ADDR_W        = 32,
    parameter int FIFO_DEPTH    = 64,
    parameter int MAX_BURST_LOG = 4,
    parameter int LEN_W         = 5,
    parameter int FILL_W        = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LEN_W-1:0]  mem_len,
    input logic              mem_gnt,
    input logic              mem_done,
    input logic              pix_pop,
    input logic [FILL_W-1:0] fifo_level,
    input logic [FILL_W-1:0] fifo_thresh,
    input logic              frame_end,
    input logic              pal_done,
    input logic              underflow
);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_len)));

    assert_len_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_len != '0) && (int'(mem_len) <= (1 << MAX_BURST_LOG))));

    assert_uflow_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> ($past(pix_pop) && ($past(fifo_level) == '0)));

    assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_level) <= FIFO_DEPTH);

    assert_events_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_end && pal_done));

    assert_event_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end || pal_done) |-> $past(mem_done));

    assert_thresh_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> ($past(fifo_level) <= $past(fifo_thresh)));

endmodule

bind fetch_addr_seq fas_checks #(
    .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .MAX_BURST_LOG(MAX_BURST_LOG),
    .LEN_W(LEN_W), .FILL_W(FILL_W)
) u_checks (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_len(mem_len), .mem_gnt(mem_gnt), .mem_done(mem_done), .pix_pop(pix_pop),
    .fifo_level(fifo_level), .fifo_thresh(fifo_thresh), .frame_end(frame_end),
    .pal_done(pal_done), .underflow(underflow)
);

// File: tb/fetch_addr_seq_bench.sv
module fetch_addr_seq_bench;

    localparam int ADDR_W = 32;
    localparam int FILL_W = 7;
    localparam int LEN_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run_en = 1'b0;
    logic              mode_pal = 1'b0;
    logic [2:0]        burst_sel = 3'd0;
    logic [FILL_W-1:0] fifo_thresh = 7'd48;
    logic              win_wr = 1'b0;
    logic [ADDR_W-1:0] win_base = '0;
    logic [ADDR_W-1:0] win_ceil = '0;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic [LEN_W-1:0]  mem_len;
    logic              mem_gnt = 1'b0;
    logic              mem_done = 1'b0;
    logic              pix_pop = 1'b0;
    logic [FILL_W-1:0] fifo_level;
    logic              frame_end, pal_done, underflow;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [ADDR_W-1:0] log_addr [0:63];
    int                log_len  [0:63];
    int n_log = 0;
    int fe_cnt = 0;
    int pd_cnt = 0;

    always #4 clk = ~clk;

    fetch_addr_seq u_fetch_addr_seq (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_pal(mode_pal),
        .burst_sel(burst_sel), .fifo_thresh(fifo_thresh), .win_wr(win_wr),
        .win_base(win_base), .win_ceil(win_ceil), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_len(mem_len), .mem_gnt(mem_gnt),
        .mem_done(mem_done), .pix_pop(pix_pop), .fifo_level(fifo_level),
        .frame_end(frame_end), .pal_done(pal_done), .underflow(underflow)
    );

    // memory responder: grant, then done three cycles later
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req) begin
                if (n_log < 64) begin
                    log_addr[n_log] = mem_addr;
                    log_len[n_log]  = int'(mem_len);
                    n_log++;
                end
                mem_gnt = 1'b1;
                @(negedge clk);
                mem_gnt = 1'b0;
                repeat (2) @(negedge clk);
                mem_done = 1'b1;
                @(negedge clk);
                mem_done = 1'b0;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (frame_end) fe_cnt++;
            if (pal_done)  pd_cnt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic start_run(input logic [31:0] b, input logic [31:0] c, input logic [2:0] sel,
                             input logic pal, input logic [6:0] thr);
        @(negedge clk);
        win_base = b; win_ceil = c; win_wr = 1'b1;
        burst_sel = sel; mode_pal = pal; fifo_thresh = thr;
        @(negedge clk);
        win_wr = 1'b0;
        run_en = 1'b1;
    endtask

    task automatic wait_log(input int n);
        for (int i = 0; i < 2000 && n_log < n; i++) @(negedge clk);
    endtask

    task automatic drain();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            pix_pop = (fifo_level != '0);
        end
        pix_pop = 1'b0;
    endtask

    // stop the engine; R11: no new bursts once run_en is low
    task automatic stop_run();
        int snap;
        @(negedge clk);
        run_en = 1'b0;
        repeat (10) @(negedge clk);
        snap = n_log;
        repeat (40) @(negedge clk);
        chk(n_log == snap, "R11 no burst after run_en low", n_log, snap);
        drain();
        n_log = 0;
    endtask

    task automatic test_reset();
        chk(mem_req == 1'b0, "R1 mem_req after reset", mem_req, 0);
        chk(fifo_level == '0, "R1 fifo_level after reset", fifo_level, 0);
        chk({frame_end, pal_done, underflow} == 3'b000, "R1 events after reset",
            {frame_end, pal_done, underflow}, 0);
    endtask

    task automatic test_palette();
        int pd0;
        pd0 = pd_cnt;
        start_run(32'h1000, 32'h9FFC, 3'd1, 1'b1, 7'd48);
        for (int i = 0; i < 500 && pd_cnt == pd0; i++) @(negedge clk);
        chk(n_log == 4, "R6 palette burst count", n_log, 4);
        for (int i = 0; i < 4; i++)
            chk(log_addr[i] == 32'h1000 + 32'(8 * i) && log_len[i] == 2, "R6 palette burst",
                log_addr[i], 32'h1000 + 8 * i);
        chk(pd_cnt - pd0 == 1, "R6 single pal_done", pd_cnt - pd0, 1);
        chk(fifo_level == 7'd8, "R8 level after palette", fifo_level, 8);
        repeat (30) @(negedge clk);
        chk(n_log == 4, "R6 no request after pal_done", n_log, 4);
        pix_pop = 1'b1;
        repeat (3) @(negedge clk);
        pix_pop = 1'b0;
        chk(fifo_level == 7'd5, "R8 level after three pops", fifo_level, 5);
        stop_run();
    endtask

    task automatic test_frame_shadow();
        int fe0;
        fe0 = fe_cnt;
        start_run(32'h2000, 32'h2027, 3'd2, 1'b0, 7'd48);
        wait_log(1);
        @(negedge clk);
        win_base = 32'h3000; win_ceil = 32'h300F; win_wr = 1'b1;
        @(negedge clk);
        win_wr = 1'b0;
        wait_log(5);
        chk(log_addr[0] == 32'h2000 && log_len[0] == 4, "R3 first burst", log_addr[0], 32'h2000);
        chk(log_addr[1] == 32'h2010 && log_len[1] == 4, "R5 old pass continues", log_addr[1], 32'h2010);
        chk(log_addr[2] == 32'h2020 && log_len[2] == 2, "R3 shortened final burst", log_len[2], 2);
        chk(log_addr[3] == 32'h3000 && log_len[3] == 4, "R5 new pair next pass", log_addr[3], 32'h3000);
        chk(log_addr[4] == 32'h3000 && log_len[4] == 4, "R4 wrap to base", log_addr[4], 32'h3000);
        chk(fe_cnt - fe0 >= 2, "R4 frame_end pulses", fe_cnt - fe0, 2);
        stop_run();
    endtask

    task automatic test_burst_sizes();
        start_run(32'h5000, 32'h503F, 3'd4, 1'b0, 7'd48);
        wait_log(2);
        chk(log_addr[0] == 32'h5000 && log_len[0] == 16, "R2 sel4 16 words", log_len[0], 16);
        chk(log_addr[1] == 32'h5000 && log_len[1] == 16, "R4 single-burst wrap", log_addr[1], 32'h5000);
        stop_run();
        start_run(32'h6000, 32'h600B, 3'd0, 1'b0, 7'd48);
        wait_log(4);
        chk(log_addr[1] == 32'h6004 && log_len[1] == 1, "R2 sel0 one word", log_addr[1], 32'h6004);
        chk(log_addr[3] == 32'h6000 && log_len[3] == 1, "R4 wrap after three words", log_addr[3], 32'h6000);
        stop_run();
        start_run(32'h7000, 32'h707F, 3'd7, 1'b0, 7'd48);
        wait_log(2);
        chk(log_len[0] == 16 && log_addr[1] == 32'h7040, "R2 sel7 acts as 16", log_len[0], 16);
        stop_run();
    endtask

    task automatic test_threshold();
        start_run(32'h4000, 32'h403F, 3'd2, 1'b0, 7'd0);
        wait_log(1);
        repeat (30) @(negedge clk);
        chk(n_log == 1, "R7 stall while level above threshold", n_log, 1);
        chk(fifo_level == 7'd4, "R8 level after one burst", fifo_level, 4);
        pix_pop = 1'b1;
        repeat (4) @(negedge clk);
        pix_pop = 1'b0;
        wait_log(2);
        chk(n_log == 2 && log_addr[1] == 32'h4010, "R7 resume after drain", log_addr[1], 32'h4010);
        stop_run();
    endtask

    task automatic test_underflow();
        chk(fifo_level == '0, "R9 precondition empty", fifo_level, 0);
        @(negedge clk);
        pix_pop = 1'b1;
        @(negedge clk);
        pix_pop = 1'b0;
        chk(underflow == 1'b1, "R9 underflow pulse", underflow, 1);
        chk(fifo_level == '0, "R9 level stays zero", fifo_level, 0);
        @(negedge clk);
        chk(underflow == 1'b0, "R9 pulse one cycle", underflow, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_palette();
        test_frame_shadow();
        test_burst_sizes();
        test_threshold();
        test_underflow();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule